// File: doc/BRIEF.md
# Synchronous Parallel FIFO Link Master

This block is the master end of a half-duplex parallel link to a USB bridge device. The bridge supplies the clock that the block runs on. Two active-low flags from the bridge report its state: one says it holds received bytes, and the other says it has room for bytes to send. The master drives active-low read, write and output-enable strobes onto the link. The data bus is shared by both directions and is split here into an input path, an output path and a drive-enable. The pad ring turns these three into a tristate.

On the user side, bytes read from the bridge leave through a valid/ready sink. Bytes to be written enter through a valid/ready source. When both directions have work, a small arbiter grants whole bursts and alternates between reads and writes. Each burst is capped at a parameterised number of bytes, so one side cannot hold the bus indefinitely. Every read burst starts with one turnaround cycle. In that cycle output-enable is low, the master's bus drivers are off, and the read strobe is still high.

Top module: `sfifo_bridge_master`

## Requirements
- R1: While reset is asserted, `rd_n`, `wr_n` and `oe_n` are high, `bus_drive` is low, and `rx_valid` and `tx_ready` are low.
- R2: A read burst begins with exactly one cycle in which `oe_n` is low, `rd_n` is high and `bus_drive` is low. `oe_n` stays low in every cycle in which `rd_n` is low.
- R3: A byte is read on each rising edge where `rd_n` and `avail_n` are both low. That byte appears on `rx_data` with `rx_valid` high in the same cycle. `rd_n` is never low while `rx_ready` is low.
- R4: If `avail_n` is high while `rd_n` is low, or if `rx_ready` drops during a read burst, then in the next cycle `rd_n` and `oe_n` are both high.
- R5: `wr_n` is low only while `space_n` is low and `tx_valid` is high. In that cycle `bus_drive` is high, `bus_out` equals `tx_data` and `tx_ready` is high. A byte is written on each edge where `wr_n` and `space_n` are both low.
- R6: `bus_drive` is never high while `oe_n` is low. `wr_n` is never low while `oe_n` is low.
- R7: A burst in either direction moves at most `BURST_MAX` bytes (default 8) and then returns to idle.
- R8: When both directions are ready at an idle cycle, the direction opposite to the previous burst is granted. The first grant after reset goes to a read.
- R9: Bytes are delivered in order and without loss or duplication in both directions, under any pattern of stalls on the flags, the sink and the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock supplied by the bridge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Data bus value seen at the pad |
| bus_out | output | 8 | Data the master drives onto the bus |
| bus_drive | output | 1 | High when the master drives the bus |
| avail_n | input | 1 | Low when the bridge holds received bytes |
| space_n | input | 1 | Low when the bridge can accept bytes |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low bridge output enable |
| rx_data | output | 8 | Byte read from the bridge |
| rx_valid | output | 1 | `rx_data` holds a byte this cycle |
| rx_ready | input | 1 | User sink can take a byte |
| tx_data | input | 8 | Byte to write to the bridge |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Byte on `tx_data` is taken this cycle |

## Verification
The transfer path is tried under several conditions:
- reads only, writes only, and both directions contending with no stalls, which separates the single-direction paths from the arbiter;
- a gappy receive flag, a gappy space flag, a stalling sink and a gappy source, each on its own, which shows whether each exit condition ends a burst without losing or repeating a byte;
- all stalls combined.

Directed cases cover:
- the exact cycle the preamble and the first byte arrive;
- the cycle the strobes fall back after the flag rises or the sink stalls;
- a write held off by a full bridge;
- the 8-8-8 run lengths that show both the cap and the alternation.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_PRE  = 2'd1,
    ST_RD_XFER = 2'd2,
    ST_WR_XFER = 2'd3
  } sfb_state_e;

  // Read wins unless a write also waits and the previous burst was a read.
  function automatic logic pick_read(input logic rd_req, input logic wr_req,
                                     input logic last_was_rd);
    return rd_req && (!wr_req || !last_was_rd);
  endfunction

  // A burst closes when its flag or user side stalls, or on its final beat.
  function automatic logic burst_ends(input logic stalled, input logic fire,
                                      input logic last_beat);
    return stalled || (fire && last_beat);
  endfunction

endpackage

// File: rtl/sfb_arb.sv
module sfb_arb
  import sfb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic grant_en,
  input  logic rd_req,
  input  logic wr_req,
  output logic start_rd,
  output logic start_wr
);

  logic last_rd_q;
  logic want_rd;

  assign want_rd  = pick_read(rd_req, wr_req, last_rd_q);
  assign start_rd = grant_en && want_rd;
  assign start_wr = grant_en && wr_req && !want_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        last_rd_q <= 1'b0;
    else if (start_rd) last_rd_q <= 1'b1;
    else if (start_wr) last_rd_q <= 1'b0;
  end

endmodule

// File: rtl/sfb_burst_cnt.sv
module sfb_burst_cnt #(
  parameter int BURST_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_beat
);

  localparam int CW = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1;
  localparam logic [CW-1:0] LAST = CW'(BURST_MAX - 1);

  logic [CW-1:0] cnt_q;

  assign last_beat = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/sfifo_bridge_master.sv
module sfifo_bridge_master
  import sfb_pkg::*;
#(
  parameter int DW        = 8,
  parameter int BURST_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_drive,
  input  logic          avail_n,
  input  logic          space_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          oe_n,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready
);

  sfb_state_e state_q, state_d;

  // Named internal events, kept visible for the checker and for waveforms.
  logic in_pre, in_rd, in_wr, in_idle;
  logic rd_go, wr_go, rd_fire, wr_fire;
  logic rd_req, wr_req, start_rd, start_wr;
  logic last_beat;

  assign in_idle = (state_q == ST_IDLE);
  assign in_pre  = (state_q == ST_RD_PRE);
  assign in_rd   = (state_q == ST_RD_XFER);
  assign in_wr   = (state_q == ST_WR_XFER);

  assign rd_req = !avail_n && rx_ready;
  assign wr_req = !space_n && tx_valid;

  assign rd_go   = in_rd && rx_ready;
  assign rd_fire = rd_go && !avail_n;
  assign wr_go   = in_wr && tx_valid && !space_n;
  assign wr_fire = wr_go;

  assign rd_n      = !rd_go;
  assign oe_n      = !(in_pre || in_rd);
  assign wr_n      = !wr_go;
  assign bus_drive = in_wr;
  assign bus_out   = tx_data;
  assign tx_ready  = in_wr && !space_n;
  assign rx_data   = bus_in;
  assign rx_valid  = rd_fire;

  sfb_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_en (in_idle),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .start_rd (start_rd),
    .start_wr (start_wr)
  );

  sfb_burst_cnt #(.BURST_MAX(BURST_MAX)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_rd || start_wr),
    .inc       (rd_fire || wr_fire),
    .last_beat (last_beat)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rd)      state_d = ST_RD_PRE;
        else if (start_wr) state_d = ST_WR_XFER;
      end
      ST_RD_PRE:  state_d = ST_RD_XFER;
      ST_RD_XFER: if (burst_ends(avail_n || !rx_ready, rd_fire, last_beat))
                    state_d = ST_IDLE;
      ST_WR_XFER: if (burst_ends(space_n || !tx_valid, wr_fire, last_beat))
                    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/sfb_master_chk.sv
module sfb_master_chk #(
  parameter int BURST_MAX = 8
) (
  input logic clk,
  input logic rst_n,
  input logic rd_n,
  input logic wr_n,
  input logic oe_n,
  input logic bus_drive,
  input logic avail_n,
  input logic space_n,
  input logic rx_ready,
  input logic tx_valid
);

  localparam int CW = $clog2(BURST_MAX + 2);

  logic [CW-1:0] rd_beats, wr_beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_beats <= '0;
      wr_beats <= '0;
    end else begin
      if (oe_n)                     rd_beats <= '0;
      else if (!rd_n && !avail_n)   rd_beats <= rd_beats + 1'b1;
      if (!bus_drive)               wr_beats <= '0;
      else if (!wr_n && !space_n)   wr_beats <= wr_beats + 1'b1;
    end
  end

  a_r2_oe_leads_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($past(!oe_n) && !oe_n));

  a_r2_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !oe_n);

  a_r3_rd_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> rx_ready);

  a_r4_rd_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && avail_n) |=> (rd_n && oe_n));

  a_r5_wr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!space_n && tx_valid && bus_drive));

  a_r6_oe_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !bus_drive);

  a_r6_wr_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> oe_n);

  a_r7_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_beats) <= BURST_MAX) && (int'(wr_beats) <= BURST_MAX));

endmodule

bind sfifo_bridge_master sfb_master_chk #(.BURST_MAX(BURST_MAX)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .oe_n      (oe_n),
  .bus_drive (bus_drive),
  .avail_n   (avail_n),
  .space_n   (space_n),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid)
);

// File: tb/sfifo_bridge_master_tb.sv
module sfifo_bridge_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = 8'h00, bus_out, tx_data = 8'h00, rx_data;
  logic       bus_drive, rd_n, wr_n, oe_n, rx_valid, tx_ready;
  logic       avail_n = 1'b1, space_n = 1'b1, rx_ready = 1'b0, tx_valid = 1'b0;

  always #10 clk = ~clk;

  sfifo_bridge_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_drive(bus_drive), .avail_n(avail_n), .space_n(space_n),
    .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  // Fields: rx count, tx count, avail stall mask, space stall mask,
  // sink stall mask, source gap mask (bit k applies on cycle k mod 8).
  localparam logic [47:0] VEC [8] = '{
    {8'd5,  8'd0,  8'h00, 8'h00, 8'h00, 8'h00},
    {8'd0,  8'd5,  8'h00, 8'h00, 8'h00, 8'h00},
    {8'd12, 8'd12, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'd10, 8'd0,  8'h49, 8'h00, 8'h00, 8'h00},
    {8'd0,  8'd10, 8'h00, 8'h30, 8'h00, 8'h00},
    {8'd12, 8'd0,  8'h00, 8'h00, 8'h82, 8'h00},
    {8'd0,  8'd12, 8'h00, 8'h00, 8'h00, 8'h44},
    {8'd30, 8'd30, 8'h21, 8'h84, 8'h10, 8'h08}
  };

  int nchk = 0, nfail = 0;
  logic [7:0] rq [64], txq [64], gotr [64], gotw [64];
  int rn, tn, rhead, tidx, gr, gw, c, viol, nrun, cur_dir;
  int runlen [16];
  int rundir [16];
  logic [7:0] av_mask, sp_mask, rdy_mask, val_mask;
  bit pend_r, pend_w, rdy_lo, prev_oe_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_inputs();
    avail_n  = !((rhead < rn) && !av_mask[c % 8]);
    bus_in   = (rhead < rn) ? rq[rhead] : 8'h00;
    space_n  = sp_mask[c % 8];
    rx_ready = !rdy_mask[c % 8] && !rdy_lo;
    tx_valid = (tidx < tn) && !val_mask[c % 8];
    tx_data  = (tidx < tn) ? txq[tidx] : 8'h00;
  endtask

  task automatic step();
    @(negedge clk);
    if (pend_r) rhead++;
    if (pend_w) tidx++;
    c++;
    drive_inputs();
    #1;
    pend_r = !rd_n && !avail_n;
    pend_w = !wr_n && !space_n;
    // protocol rules (R2, R3, R5, R6)
    if (!oe_n && bus_drive)                    viol++;
    if (!wr_n && !oe_n)                        viol++;
    if (!rd_n && (oe_n || prev_oe_n))          viol++;
    if (!rd_n && !rx_ready)                    viol++;
    if (rx_valid != pend_r)                    viol++;
    if (!wr_n && !(bus_drive && tx_valid && !space_n)) viol++;
    if (pend_w && (bus_out != tx_data || !tx_ready))   viol++;
    if (pend_r && gr < 64) begin gotr[gr] = rx_data; gr++; end
    if (pend_w && gw < 64) begin gotw[gw] = bus_out; gw++; end
    if (pend_r || pend_w) begin
      if (cur_dir != (pend_r ? 1 : 0) && nrun < 16) begin
        cur_dir = pend_r ? 1 : 0;
        rundir[nrun] = cur_dir;
        runlen[nrun] = 0;
        nrun++;
      end
      if (nrun > 0) runlen[nrun-1]++;
    end
    prev_oe_n = oe_n;
  endtask

  task automatic clear_model();
    rn = 0; tn = 0; rhead = 0; tidx = 0; gr = 0; gw = 0; viol = 0;
    nrun = 0; cur_dir = -1; pend_r = 0; pend_w = 0; rdy_lo = 0; prev_oe_n = 1;
    av_mask = 0; sp_mask = 0; rdy_mask = 0; val_mask = 0;
  endtask

  task automatic fill(input int v);
    for (int i = 0; i < 64; i++) begin
      rq[i]  = 8'(8'h30 + i * 7 + v);
      txq[i] = 8'(8'hA0 ^ (i * 3 + v));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clear_model();
    drive_inputs();
    repeat (2) @(negedge clk);
    #1;
    // R1: idle outputs under reset
    chk(rd_n && wr_n && oe_n && !bus_drive && !rx_valid && !tx_ready, "R1",
        {rd_n, wr_n, oe_n, bus_drive, rx_valid, tx_ready}, 6'b111000);
    rst_n = 1'b1;
  endtask

  task automatic run_done();
    for (int g = 0; g < 800; g++) begin
      if (rhead >= rn && tidx >= tn && !pend_r && !pend_w) break;
      step();
    end
    repeat (3) step();
  endtask

  task automatic check_streams(input string tag);
    bit okr = 1, okw = 1;
    for (int i = 0; i < rn; i++) if (gotr[i] != rq[i]) okr = 0;
    for (int i = 0; i < tn; i++) if (gotw[i] != txq[i]) okw = 0;
    chk(gr == rn, {tag, " R9 rx count"}, gr, rn);
    chk(okr, {tag, " R3 rx data order"}, okr, 1);
    chk(gw == tn, {tag, " R9 tx count"}, gw, tn);
    chk(okw, {tag, " R5 tx data order"}, okw, 1);
    chk(viol == 0, {tag, " R2 R6 protocol"}, viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    c = 0;
    clear_model();
    do_reset();

    // vector table, back to back
    for (int v = 0; v < 8; v++) begin
      fill(v);
      gr = 0; gw = 0; viol = 0; rhead = 0; tidx = 0;
      {rn, tn} = {24'd0, VEC[v][47:40], 24'd0, VEC[v][39:32]};
      av_mask  = VEC[v][31:24];
      sp_mask  = VEC[v][23:16];
      rdy_mask = VEC[v][15:8];
      val_mask = VEC[v][7:0];
      run_done();
      check_streams($sformatf("vec%0d", v));
      av_mask = 0; sp_mask = 0; rdy_mask = 0; val_mask = 0;
    end

    // R2 R3 R4: preamble timing and stop after the flag rises
    do_reset(); fill(20); rn = 3;
    step();
    step();
    chk(!oe_n && rd_n && !bus_drive, "R2 preamble", {oe_n, rd_n, bus_drive}, 3'b010);
    step();
    chk(!rd_n && rx_valid && rx_data == rq[0], "R3 first byte", rx_data, rq[0]);
    step(); step();
    chk(rx_valid && rx_data == rq[2], "R3 third byte", rx_data, rq[2]);
    step();
    step();
    chk(rd_n && oe_n, "R4 stop after flag", {rd_n, oe_n}, 2'b11);

    // R3 R4: sink stall mid burst
    do_reset(); fill(21); rn = 5;
    step(); step(); step();
    rdy_lo = 1;
    step();
    chk(rd_n && !rx_valid, "R3 strobe gated by ready", {rd_n, rx_valid}, 2'b10);
    step();
    chk(oe_n && rd_n, "R4 burst left on stall", {oe_n, rd_n}, 2'b11);
    rdy_lo = 0;
    run_done();
    check_streams("stall");

    // R5 R6: write held while bridge is full
    do_reset(); fill(22); tn = 2; sp_mask = 8'hFF;
    begin
      bit held = 1;
      for (int i = 0; i < 4; i++) begin
        step();
        if (!wr_n || bus_drive || tx_ready) held = 0;
      end
      chk(held, "R5 write held off", held, 1);
    end
    sp_mask = 8'h00;
    step();
    step();
    chk(!wr_n && bus_drive && oe_n && tx_ready && bus_out == txq[0], "R5 R6 write start",
        bus_out, txq[0]);
    step();
    chk(!wr_n && bus_out == txq[1], "R5 second byte", bus_out, txq[1]);
    run_done();
    check_streams("wr");

    // R7 R8: both directions contend, burst cap 8
    do_reset(); fill(23); rn = 20; tn = 20;
    run_done();
    chk(nrun >= 3 && rundir[0] == 1 && runlen[0] == 8, "R8 R7 first run read x8",
        runlen[0], 8);
    chk(rundir[1] == 0 && runlen[1] == 8, "R8 R7 second run write x8", runlen[1], 8);
    chk(rundir[2] == 1 && runlen[2] == 8, "R8 third run read", runlen[2], 8);
    check_streams("arb");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule